// File: doc/BRIEF.md
# Stream ingress buffer with early-warning flag

This block sits between a transmit client that sends AXI4-Stream beats and a line-side consumer that pulls them. Beats enter through a tvalid/tready handshake. Each beat is stored together with its tlast bit, in arrival order. The drain side presents the oldest stored beat with a valid signal and removes it when the consumer accepts it. Both sides run on one clock.

Beside tready, the block drives an almost-full flag. The flag rises at least one cycle before tready falls, so a client that cannot react within the same cycle to a tready drop can slow down in time. A static 6-bit input sets how early the warning comes: a larger value raises the flag while more free space is left. The flag stays high until the buffer has drained past the trip point plus a hysteresis of one beat. tready is computed from occupancy alone and never from tvalid, so a client that goes idle does not block recovery.

Top module: `stream_ingress_buf`

## Requirements
- R1: A beat (tdata and tlast) is written on a rising clock edge only when `s_tvalid_i` and `s_tready_o` are both high.
- R2: `m_valid_o` is high whenever the buffer holds at least one beat. The oldest beat is presented with its tlast bit on `m_last_o`, and it is removed on an edge where `m_valid_o` and `m_accept_i` are both high. While the beat is not accepted, `m_data_o` and `m_last_o` hold steady. Beats leave in arrival order.
- R3: `s_tready_o` is registered and falls after the edge on which free space drops to `RSV_BEATS` (default 0: after `DEPTH`=128 stored beats with no drain). While it is low, presented beats are not stored, and it stays low until a beat is drained.
- R4: `s_taf_o` is registered and rises after the edge on which free space becomes at most `af_thresh_i + RSV_BEATS + 1`. With threshold 0 this happens after 127 stored beats and not after 126.
- R5: `s_taf_o` is high in the cycle before every falling edge of `s_tready_o`, and it is high whenever `s_tready_o` is low.
- R6: Once set, `s_taf_o` clears only after free space reaches `af_thresh_i + RSV_BEATS + 3`. With threshold 0 and a full buffer, it is still high after 2 drained beats and low after 3.
- R7: `s_tready_o` returns high after a drain frees space, even while `s_tvalid_i` is held low.
- R8: While `rst_ni` is low the buffer is emptied, `m_valid_o` is low, `s_tready_o` is high and `s_taf_o` is low.
- R9: `af_thresh_i` is a 6-bit unsigned value. At 0x3F the flag rises after 64 stored beats (free space 64) and not after 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both sides |
| rst_ni | input | 1 | Asynchronous reset, active low |
| af_thresh_i | input | 6 | Static early-warning threshold |
| s_tdata_i | input | DW | Client beat data |
| s_tlast_i | input | 1 | Client end-of-frame marker |
| s_tvalid_i | input | 1 | Client beat valid |
| s_tready_o | output | 1 | Buffer can take a beat |
| s_taf_o | output | 1 | Almost-full early warning |
| m_data_o | output | DW | Drain-side beat data |
| m_last_o | output | 1 | Drain-side end-of-frame marker |
| m_valid_o | output | 1 | Drain-side beat available |
| m_accept_i | input | 1 | Consumer takes the presented beat |

## Verification
The hardest states to reach are the exact occupancies where the flag and tready switch, and the backward path in which the flag clears after a drain. The drain stays stopped while the bench writes back-to-back beats one at a time and checks both flags after each count near the boundary. It keeps offering beats while tready is low, so that a wrongly accepted beat shows up in the scoreboard. It then drains single beats with tvalid low to step through tready recovery and the hysteresis band. The same fill is repeated at threshold 0x3F to exercise the widest warning setting.

// File: rtl/sib_pkg.sv
package sib_pkg;
  typedef enum logic [1:0] {
    AF_HOLD = 2'd0,
    AF_SET  = 2'd1,
    AF_CLR  = 2'd2
  } af_act_e;

  localparam int unsigned THR_W = 6;
endpackage

// File: rtl/sib_store.sv
module sib_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_ptr_i,
  input  logic [DW:0]   wr_beat_i,
  input  logic [AW-1:0] rd_ptr_i,
  output logic [DW:0]   rd_beat_o
);
  logic [DW:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_i] <= wr_beat_i;
  end

  assign rd_beat_o = mem_q[rd_ptr_i];
endmodule

// File: rtl/sib_ptrs.sv
module sib_ptrs #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] count_nxt_o
);
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    count_nxt_o = count_q;
    if (wr_i && !rd_i)      count_nxt_o = count_q + CW'(1);
    else if (!wr_i && rd_i) count_nxt_o = count_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= bump(wr_ptr_q);
      if (rd_i) rd_ptr_q <= bump(rd_ptr_q);
      count_q <= count_nxt_o;
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign count_o  = count_q;
endmodule

// File: rtl/sib_flow.sv
module sib_flow
  import sib_pkg::*;
#(
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned RSV_BEATS = 0,
  localparam int unsigned CW       = $clog2(DEPTH + 1),
  localparam int unsigned LW       = CW + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    count_nxt_i,
  input  logic [THR_W-1:0] thresh_i,
  output logic             ready_o,
  output logic             af_o
);
  logic [LW-1:0] free_w, set_lvl, clr_lvl;
  af_act_e       act;
  logic          ready_q, af_q;

  always_comb begin
    free_w  = LW'(DEPTH) - LW'(count_nxt_i);
    set_lvl = LW'(thresh_i) + LW'(RSV_BEATS) + LW'(1);
    clr_lvl = set_lvl + LW'(2);
    if (free_w <= set_lvl)      act = AF_SET;
    else if (free_w >= clr_lvl) act = AF_CLR;
    else                        act = AF_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
      af_q    <= 1'b0;
    end else begin
      ready_q <= free_w > LW'(RSV_BEATS);
      case (act)
        AF_SET:  af_q <= 1'b1;
        AF_CLR:  af_q <= 1'b0;
        default: af_q <= af_q;
      endcase
    end
  end

  assign ready_o = ready_q;
  assign af_o    = af_q;
endmodule

// File: rtl/stream_ingress_buf.sv
module stream_ingress_buf
  import sib_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned RSV_BEATS = 0,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [THR_W-1:0] af_thresh_i,
  input  logic [DW-1:0]    s_tdata_i,
  input  logic             s_tlast_i,
  input  logic             s_tvalid_i,
  output logic             s_tready_o,
  output logic             s_taf_o,
  output logic [DW-1:0]    m_data_o,
  output logic             m_last_o,
  output logic             m_valid_o,
  input  logic             m_accept_i
);
  logic          wr, rd;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, count_nxt;
  logic [DW:0]   rd_beat;

  assign wr        = s_tvalid_i && s_tready_o;
  assign m_valid_o = count != '0;
  assign rd        = m_valid_o && m_accept_i;

  sib_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr),
    .rd_i        (rd),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .count_o     (count),
    .count_nxt_o (count_nxt)
  );

  sib_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr),
    .wr_ptr_i  (wr_ptr),
    .wr_beat_i ({s_tlast_i, s_tdata_i}),
    .rd_ptr_i  (rd_ptr),
    .rd_beat_o (rd_beat)
  );

  sib_flow #(.DEPTH(DEPTH), .RSV_BEATS(RSV_BEATS)) u_flow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .count_nxt_i (count_nxt),
    .thresh_i    (af_thresh_i),
    .ready_o     (s_tready_o),
    .af_o        (s_taf_o)
  );

  assign m_last_o = rd_beat[DW];
  assign m_data_o = rd_beat[DW-1:0];
endmodule

// File: rtl/stream_ingress_buf_chk.sv
module stream_ingress_buf_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          s_tready_o,
  input logic          s_taf_o,
  input logic [DW-1:0] m_data_o,
  input logic          m_last_o,
  input logic          m_valid_o,
  input logic          m_accept_i
);
  a_r5_af_leads_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(s_tready_o) |-> $past(s_taf_o));

  a_r5_af_covers_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_tready_o |-> s_taf_o);

  a_r3_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s_tready_o && !(m_valid_o && m_accept_i)) |=> !s_tready_o);

  a_r6_af_needs_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_taf_o && !(m_valid_o && m_accept_i)) |=> s_taf_o);

  a_r2_beat_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_accept_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_last_o)));
endmodule

bind stream_ingress_buf stream_ingress_buf_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .s_tready_o (s_tready_o),
  .s_taf_o    (s_taf_o),
  .m_data_o   (m_data_o),
  .m_last_o   (m_last_o),
  .m_valid_o  (m_valid_o),
  .m_accept_i (m_accept_i)
);

// File: tb/stream_ingress_buf_bench.sv
`timescale 1ns/1ps
module stream_ingress_buf_bench;
  localparam int DW    = 32;
  localparam int DEPTH = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    thresh = 6'd0;
  logic [DW-1:0] tdata = '0;
  logic          tlast = 1'b0;
  logic          tvalid = 1'b0;
  logic          tready, taf;
  logic [DW-1:0] m_data;
  logic          m_last, m_valid;
  logic          accept = 1'b0;

  int          n_chk = 0;
  int          n_fail = 0;
  int          seq = 0;
  logic [DW:0] exp_q[$];

  always #4 clk = ~clk;

  stream_ingress_buf #(.DW(DW), .DEPTH(DEPTH)) u_stream_ingress_buf (
    .clk_i(clk), .rst_ni(rst_n), .af_thresh_i(thresh),
    .s_tdata_i(tdata), .s_tlast_i(tlast), .s_tvalid_i(tvalid),
    .s_tready_o(tready), .s_taf_o(taf),
    .m_data_o(m_data), .m_last_o(m_last), .m_valid_o(m_valid),
    .m_accept_i(accept)
  );

  task automatic chk(input logic ok, input string req, input logic [DW:0] act, input logic [DW:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares drained beats against the scoreboard
  always @(negedge clk) begin
    if (rst_n && m_valid && accept) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected beat", {m_last, m_data}, '0);
      else begin
        logic [DW:0] e;
        e = exp_q.pop_front();
        chk({m_last, m_data} == e, "R1/R2 beat order and tlast", {m_last, m_data}, e);
      end
    end
  end

  // driver: presents one beat until accepted, pushes it when the handshake is seen
  task automatic put();
    logic acc;
    tdata  = DW'(32'hA500_0000 + seq);
    tlast  = (seq % 5) == 4;
    tvalid = 1'b1;
    do begin
      @(negedge clk);
      acc = tready;
      if (acc) exp_q.push_back({tlast, tdata});
      @(posedge clk); #1;
    end while (!acc);
    tvalid = 1'b0;
    seq++;
  endtask

  task automatic drain_n(input int n);
    for (int i = 0; i < n; i++) begin
      accept = 1'b1;
      @(posedge clk); #1;
      accept = 1'b0;
    end
  endtask

  task automatic drain_all();
    accept = 1'b1;
    for (int i = 0; i < 400 && (m_valid || exp_q.size() != 0); i++) begin
      @(posedge clk); #1;
    end
    accept = 1'b0;
    chk(!m_valid && exp_q.size() == 0, "R2 drained empty", {DW'(0), m_valid}, '0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(tready == 1'b1, "R8 tready in reset", {DW'(0), tready}, 1);
    chk(taf == 1'b0, "R8 af in reset", {DW'(0), taf}, 0);
    chk(m_valid == 1'b0, "R8 empty in reset", {DW'(0), m_valid}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1/R2: streaming with drain running, gaps on both sides
    accept = 1'b1;
    for (int i = 0; i < 24; i++) begin
      put();
      if (i % 3 == 2) begin @(posedge clk); #1; end
      accept = (i % 4) != 1;
    end
    drain_all();

    // R3/R4/R5: fill with no drain, threshold 0
    thresh = 6'd0;
    for (int i = 1; i <= DEPTH; i++) begin
      put();
      if (i == 126) chk(taf == 1'b0, "R4 af low at 126", {DW'(0), taf}, 0);
      if (i == 127) begin
        chk(taf == 1'b1, "R4 af high at 127", {DW'(0), taf}, 1);
        chk(tready == 1'b1, "R5 tready still high when af rises", {DW'(0), tready}, 1);
      end
      if (i == 128) chk(tready == 1'b0, "R3 tready low when full", {DW'(0), tready}, 0);
    end
    chk(m_data == 32'hA500_0000 + 32'(seq - DEPTH), "R2 oldest beat presented",
        {m_last, m_data}, {1'b0, 32'hA500_0000 + 32'(seq - DEPTH)});
    // offer beats while stalled; none may be stored
    tdata = 32'hDEAD_BEEF; tlast = 1'b1; tvalid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (tready) exp_q.push_back({tlast, tdata});
      @(posedge clk); #1;
      chk(tready == 1'b0, "R3 stall holds with tvalid high", {DW'(0), tready}, 0);
    end
    tvalid = 1'b0;
    chk(exp_q.size() == DEPTH, "R3 no beat taken while stalled", DW'(exp_q.size()), DW'(DEPTH));

    // R7/R6: drain singly with tvalid low
    drain_n(1);
    chk(tready == 1'b1, "R7 tready recovers with tvalid low", {DW'(0), tready}, 1);
    chk(taf == 1'b1, "R6 af held at free 1", {DW'(0), taf}, 1);
    drain_n(1);
    chk(taf == 1'b1, "R6 af held at free 2", {DW'(0), taf}, 1);
    drain_n(1);
    chk(taf == 1'b0, "R6 af clears at free 3", {DW'(0), taf}, 0);
    drain_all();

    // R9: widest threshold
    thresh = 6'h3F;
    @(posedge clk); #1;
    for (int i = 1; i <= 64; i++) begin
      put();
      if (i == 63) chk(taf == 1'b0, "R9 af low at 63", {DW'(0), taf}, 0);
      if (i == 64) chk(taf == 1'b1, "R9 af high at 64", {DW'(0), taf}, 1);
    end
    chk(tready == 1'b1, "R9 tready high at 64", {DW'(0), tready}, 1);
    drain_all();
    chk(taf == 1'b0 && tready == 1'b1, "R8 idle flags after drain", {DW'(0), taf}, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule